// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a behavioural target for a two-wire serial memory of 4096 bytes. It oversamples the serial clock and data lines in the system clock domain and pulls the data line low through an output-enable pin, so the line itself stays open-drain outside the block. A host addresses it with a 7-bit device code whose low three bits come from strap inputs, then either loads a two-byte word address and a run of data bytes, or reads bytes back from an internal address counter.

Writes are gathered in a page buffer and land in the storage only when the host closes the transfer with a STOP. The block then runs a self-timed write cycle of a parameter-set number of system clocks, during which it answers nothing on the bus, so a host can poll for completion by sending its address until it is acknowledged. A write-protect input blocks any change to the stored bytes. Reads walk the whole array and wrap to address zero; writes stay inside their 32-byte page.

Top module: `twi_eeprom_target`

## Requirements
- R1: A falling data line while the clock line is high is a START and begins a new device-address phase from any state, discarding any unfinished byte; a rising data line while the clock line is high is a STOP and returns the target to idle with the data line released.
- R2: The first byte after START is accepted only when its upper four bits are 1010 and its next three bits equal the strap inputs; bit 0 selects read (1) or write (0). On a match the target acknowledges; otherwise it stays off the bus until the next START.
- R3: Every byte received by an addressed target in a write transfer is acknowledged by pulling the data line low during the ninth clock, and the output enable changes only while the sampled clock line is low.
- R4: A write transfer carries two word-address bytes, upper byte first; only the low 12 bits of that 16-bit value select the location.
- R5: Data bytes of a write go to successive locations where only the low five address bits advance, so the 33rd byte lands on the first location of the same 32-byte page and later bytes overwrite earlier ones.
- R6: Received data changes the storage only when a STOP ends the transfer; a START that arrives before the STOP discards the pending bytes and starts no write cycle.
- R7: A committed write starts a busy period of WRITE_CYCLES system clocks during which the target acknowledges nothing, not even its own address; afterwards it acknowledges again.
- R8: With the write-protect input high at STOP, no location changes and no busy period starts, while address and data bytes are still acknowledged.
- R9: The address counter holds the location after the last byte written or read; a read with no word address returns the byte at that counter.
- R10: A read continues while the host acknowledges each byte, stepping through the whole array and wrapping from 0xFFF to 0x000; a host no-acknowledge ends it with the data line released.
- R11: A write header that carries only the word address, followed by a repeated START and a read header, returns data starting at that word address.
- R12: After reset every location reads 0xFF, the address counter is 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND result) |
| wp_i | input | 1 | Write protect; high blocks changes to storage |
| strap_i | input | 3 | Device-select strap bits compared with the address byte |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The bench keeps the default 12-bit array and 32-byte page but shortens the write cycle to 600 system clocks, which lets an acknowledge poll land both inside and after the busy period within one run. The bus runs at one serial bit per 20 system clocks, slow enough for the two-stage input synchronizer yet fast enough to fill whole pages, overrun a page by two bytes and read across the 0xFFF to 0x000 boundary. Random page-sized write and read-back rounds with a fixed seed sit beside directed cases for strap mismatch, aborted writes and write protection.

// File: rtl/twi_eeprom_pkg.sv
// Shared types and constants for the two-wire EEPROM target.
// Assumes: 8-bit bytes, 3 strap bits in the device address byte.
package twi_eeprom_pkg;

    // Protocol phase of the target controller.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_DEV  = 3'd1,
        PH_AHI  = 3'd2,
        PH_ALO  = 3'd3,
        PH_WDAT = 3'd4,
        PH_RD   = 3'd5,
        PH_RACK = 3'd6
    } phase_t;

    localparam int          STRAP_W  = 3;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;
    localparam logic [7:0]  ERASED   = 8'hFF;

endpackage

// File: rtl/twi_bus_sampler.sv
// Synchronizes SCL/SDA into the system clock domain and flags clock edges
// and START/STOP conditions.
// Assumes: bus levels are stable for more than SYNC_STAGES+1 system clocks
// between transitions; SYNC_STAGES is at least 2.
module twi_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;

    // Shift the raw lines through the synchronizer and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_sync[SYNC_STAGES-1];
            sda_q    <= sda_sync[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode on the synchronized levels.
    always_comb begin
        scl_s     = scl_sync[SYNC_STAGES-1];
        sda_s     = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/twi_write_timer.sv
// Self-timed write cycle: a load pulse starts a countdown of WRITE_CYCLES
// system clocks; busy is high for exactly that many cycles.
// Assumes: WRITE_CYCLES is at least 1.
module twi_write_timer #(
    parameter int WRITE_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start_i) begin
            remain <= CNT_W'(WRITE_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy_o = (remain != '0);

endmodule

// File: rtl/twi_page_buffer.sv
// Holds the data bytes of one write transfer, one lane per page location,
// with a valid flag per lane; a later byte to the same lane replaces it.
// Assumes: clear has priority over a write in the same cycle.
module twi_page_buffer #(
    parameter int PAGE_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          we_i,
    input  logic [PAGE_W-1:0]             idx_i,
    input  logic [7:0]                    data_i,
    output logic [(1<<PAGE_W)-1:0][7:0]   lane_data_o,
    output logic [(1<<PAGE_W)-1:0]        lane_valid_o,
    output logic                          any_o
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    for (genvar l = 0; l < PAGE_BYTES; l++) begin : g_lane
        // Capture the byte addressed to this lane and mark it pending.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                lane_valid_o[l] <= 1'b0;
                lane_data_o[l]  <= '0;
            end else if (we_i && (idx_i == PAGE_W'(l))) begin
                lane_valid_o[l] <= 1'b1;
                lane_data_o[l]  <= data_i;
            end
        end
    end

    assign any_o = |lane_valid_o;

endmodule

// File: rtl/twi_eeprom_array.sv
// Byte storage with an asynchronous read port and a page-wide commit port
// that writes every valid buffer lane into one page row in a single cycle.
// Assumes: reset returns every byte to the erased value.
module twi_eeprom_array #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]      row_i,
    input  logic [(1<<PAGE_W)-1:0][7:0]   lane_data_i,
    input  logic [(1<<PAGE_W)-1:0]        lane_valid_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [7:0]                    rd_data_o
);
    import twi_eeprom_pkg::*;

    localparam int MEM_BYTES  = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0] mem [MEM_BYTES];

    // Erase on reset; on commit write the pending lanes of the addressed row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < MEM_BYTES; a++) begin
                mem[a] <= ERASED;
            end
        end else if (commit_i) begin
            for (int l = 0; l < PAGE_BYTES; l++) begin
                if (lane_valid_i[l]) begin
                    mem[{row_i, PAGE_W'(l)}] <= lane_data_i[l];
                end
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/twi_eeprom_ctrl.sv
// Protocol engine: receives bytes on SCL rising edges, decodes the device
// address, word address and data, drives acknowledge and read data only
// after SCL falls, and keeps the current address counter.
// Assumes: start/stop/edge strobes come from a synchronized sampler and
// never coincide with a clock edge strobe.
module twi_eeprom_ctrl #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 scl_rise,
    input  logic                                 scl_fall,
    input  logic                                 sda_s,
    input  logic                                 start_det,
    input  logic                                 stop_det,
    input  logic [twi_eeprom_pkg::STRAP_W-1:0]   strap_i,
    input  logic                                 wp_i,
    input  logic                                 busy_i,
    input  logic                                 buf_any_i,
    input  logic [7:0]                           rd_data_i,
    output logic [ADDR_W-1:0]                    addr_o,
    output logic                                 buf_we_o,
    output logic [PAGE_W-1:0]                    buf_idx_o,
    output logic [7:0]                           buf_data_o,
    output logic                                 buf_clr_o,
    output logic                                 commit_o,
    output logic                                 sda_oe_o
);
    import twi_eeprom_pkg::*;

    phase_t              phase;
    logic [3:0]          bitcnt;
    logic [2:0]          txcnt;
    logic [7:0]          shreg;
    logic [7:0]          txsh;
    logic [7:0]          addr_hi;
    logic                ack_slot;
    logic                host_ack;
    logic [ADDR_W-1:0]   addr_cnt;
    logic [15:0]         word_addr;
    logic                byte_done;
    logic                dev_hit;

    // Decode helpers for a just-completed received byte.
    always_comb begin
        byte_done = scl_fall && !ack_slot && (bitcnt == 4'd8);
        dev_hit   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i) && !busy_i;
        word_addr = {addr_hi, shreg};
    end

    // Buffer and commit strobes toward the page buffer and storage.
    always_comb begin
        buf_we_o   = byte_done && (phase == PH_WDAT);
        buf_idx_o  = addr_cnt[PAGE_W-1:0];
        buf_data_o = shreg;
        buf_clr_o  = start_det || stop_det;
        commit_o   = stop_det && buf_any_i && !wp_i;
        addr_o     = addr_cnt;
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            txcnt    <= '0;
            shreg    <= '0;
            txsh     <= '0;
            addr_hi  <= '0;
            ack_slot <= 1'b0;
            host_ack <= 1'b0;
            addr_cnt <= '0;
            sda_oe_o <= 1'b0;
        end else if (start_det) begin
            phase    <= PH_DEV;
            bitcnt   <= '0;
            ack_slot <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (stop_det) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            ack_slot <= 1'b0;
            sda_oe_o <= 1'b0;
        end else begin
            case (phase)
                PH_DEV, PH_AHI, PH_ALO, PH_WDAT: begin
                    if (scl_rise && !ack_slot) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && ack_slot) begin
                        ack_slot <= 1'b0;
                        sda_oe_o <= 1'b0;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        case (phase)
                            PH_DEV: begin
                                if (dev_hit) begin
                                    ack_slot <= 1'b1;
                                    sda_oe_o <= 1'b1;
                                    phase    <= shreg[0] ? PH_RD : PH_AHI;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_AHI: begin
                                ack_slot <= 1'b1;
                                sda_oe_o <= 1'b1;
                                addr_hi  <= shreg;
                                phase    <= PH_ALO;
                            end
                            PH_ALO: begin
                                ack_slot <= 1'b1;
                                sda_oe_o <= 1'b1;
                                addr_cnt <= word_addr[ADDR_W-1:0];
                                phase    <= PH_WDAT;
                            end
                            default: begin
                                ack_slot <= 1'b1;
                                sda_oe_o <= 1'b1;
                                addr_cnt[PAGE_W-1:0] <= addr_cnt[PAGE_W-1:0] + 1'b1;
                            end
                        endcase
                    end
                end
                PH_RD: begin
                    if (scl_fall) begin
                        if (ack_slot) begin
                            ack_slot <= 1'b0;
                            txsh     <= rd_data_i;
                            sda_oe_o <= ~rd_data_i[7];
                            addr_cnt <= addr_cnt + 1'b1;
                            txcnt    <= '0;
                        end else if (txcnt == 3'd7) begin
                            sda_oe_o <= 1'b0;
                            phase    <= PH_RACK;
                        end else begin
                            txsh     <= {txsh[6:0], 1'b0};
                            sda_oe_o <= ~txsh[6];
                            txcnt    <= txcnt + 1'b1;
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            txsh     <= rd_data_i;
                            sda_oe_o <= ~rd_data_i[7];
                            addr_cnt <= addr_cnt + 1'b1;
                            txcnt    <= '0;
                            phase    <= PH_RD;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: begin
                    sda_oe_o <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/twi_eeprom_target.sv
// Top of the two-wire EEPROM target: sampler, protocol controller, page
// buffer, storage array and write-cycle timer.
// Assumes: the data line is open-drain outside; sda_i is the wired result.
module twi_eeprom_target #(
    parameter int ADDR_W       = 12,
    parameter int PAGE_W       = 5,
    parameter int WRITE_CYCLES = 5000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wp_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ROW_W      = ADDR_W - PAGE_W;

    logic                          scl_s;
    logic                          sda_s;
    logic                          scl_rise;
    logic                          scl_fall;
    logic                          start_det;
    logic                          stop_det;
    logic                          busy;
    logic                          commit;
    logic [ADDR_W-1:0]             cur_addr;
    logic [7:0]                    rd_data;
    logic                          buf_we;
    logic [PAGE_W-1:0]             buf_idx;
    logic [7:0]                    buf_data;
    logic                          buf_clr;
    logic                          buf_any;
    logic [PAGE_BYTES-1:0][7:0]    lane_data;
    logic [PAGE_BYTES-1:0]         lane_valid;
    logic [ROW_W-1:0]              commit_row;

    assign commit_row = cur_addr[ADDR_W-1:PAGE_W];

    twi_bus_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_eeprom_ctrl #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_s      (sda_s),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .strap_i    (strap_i),
        .wp_i       (wp_i),
        .busy_i     (busy),
        .buf_any_i  (buf_any),
        .rd_data_i  (rd_data),
        .addr_o     (cur_addr),
        .buf_we_o   (buf_we),
        .buf_idx_o  (buf_idx),
        .buf_data_o (buf_data),
        .buf_clr_o  (buf_clr),
        .commit_o   (commit),
        .sda_oe_o   (sda_oe_o)
    );

    twi_page_buffer #(
        .PAGE_W (PAGE_W)
    ) u_pbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (buf_clr),
        .we_i         (buf_we),
        .idx_i        (buf_idx),
        .data_i       (buf_data),
        .lane_data_o  (lane_data),
        .lane_valid_o (lane_valid),
        .any_o        (buf_any)
    );

    twi_eeprom_array #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .row_i        (commit_row),
        .lane_data_i  (lane_data),
        .lane_valid_i (lane_valid),
        .rd_addr_i    (cur_addr),
        .rd_data_o    (rd_data)
    );

    twi_write_timer #(
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit),
        .busy_o  (busy)
    );

endmodule

// File: rtl/twi_eeprom_checker.sv
// Temporal checks on the EEPROM target, attached with bind.
// Assumes: signals are sampled on the system clock; reset is synchronous.
module twi_eeprom_checker #(
    parameter int WRITE_CYCLES = 5000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe_o,
    input logic busy,
    input logic commit,
    input logic stop_det,
    input logic wp_i
);

    localparam int RUN_W = $clog2(WRITE_CYCLES + 2);

    logic [RUN_W-1:0] busy_run;

    // Count consecutive busy cycles to bound the write cycle length.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_run <= '0;
        end else begin
            busy_run <= busy_run + 1'b1;
        end
    end

    // R3: the target only moves the data line while the clock line is low.
    a_r3_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);

    // R7: nothing is acknowledged during the write cycle.
    a_r7_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe_o);

    // R7: a commit starts the write cycle on the next clock.
    a_r7_commit_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // R7: the write cycle never exceeds WRITE_CYCLES clocks.
    a_r7_cycle_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < RUN_W'(WRITE_CYCLES)));

    // R8: a write cycle never starts while write protect was high.
    a_r8_no_cycle_under_wp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i));

    // R1: a STOP leaves the data line released.
    a_r1_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

endmodule

bind twi_eeprom_target twi_eeprom_checker #(
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe_o (sda_oe_o),
    .busy     (busy),
    .commit   (commit),
    .stop_det (stop_det),
    .wp_i     (wp_i)
);

// File: tb/twi_eeprom_target_tb.sv
// Bench: bit-banged host against a byte-level reference model of storage
// and address counter; directed corners plus seeded random page rounds.
module twi_eeprom_target_tb;

    localparam int WC   = 600;
    localparam int Q    = 5;
    localparam int MEMN = 4096;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] ref_mem [MEMN];
    int ref_ptr = 0;

    always #5 clk = ~clk;

    assign sda_bus = sda_h & ~sda_oe;

    twi_eeprom_target #(
        .WRITE_CYCLES (WC)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_h),
        .sda_i    (sda_bus),
        .wp_i     (wp),
        .strap_i  (STRAP),
        .sda_oe_o (sda_oe)
    );

    function automatic logic [7:0] dev_byte(input logic [3:0] kind, input logic [2:0] sel, input bit rd);
        return {kind, sel, rd};
    endfunction

    function automatic int page_step(input int addr, input int n);
        int a = addr % MEMN;
        return (a & ~31) | ((a + n) & 31);
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wq(Q);
        scl_h = 1'b1; wq(Q);
        sda_h = 1'b0; wq(Q);
        scl_h = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wq(Q);
        scl_h = 1'b1; wq(Q);
        sda_h = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input bit b);
        sda_h = b; wq(Q);
        scl_h = 1'b1; wq(2*Q);
        scl_h = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output bit b);
        sda_h = 1'b1; wq(Q);
        scl_h = 1'b1; wq(Q);
        b = sda_bus; wq(Q);
        scl_h = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit r;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(r);
        acked = !r;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            get_bit(r);
            v[i] = r;
        end
        put_bit(!give_ack);
    endtask

    // Write header, word address and n data bytes; optionally STOP.
    task automatic write_frame(input int addr16, input int n, input bit do_stop,
                               input string req, input logic [7:0] fixed, input bit use_fixed);
        bit a;
        int acks = 0;
        int base = addr16 % MEMN;
        logic [7:0] vals [64];
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), a); acks += int'(a);
        send_byte(8'((addr16 >> 8) & 255), a);       acks += int'(a);
        send_byte(8'(addr16 & 255), a);              acks += int'(a);
        for (int i = 0; i < n; i++) begin
            vals[i] = use_fixed ? fixed : 8'($urandom);
            send_byte(vals[i], a); acks += int'(a);
        end
        check_eq(req, acks, n + 3);
        ref_ptr = page_step(base, n);
        if (do_stop) begin
            bus_stop();
            if (!wp) begin
                for (int i = 0; i < n; i++) ref_mem[page_step(base, i)] = vals[i];
            end
        end
    endtask

    // Read n bytes at the current counter, ack all but the last.
    task automatic read_run(input int n, input string req_hdr, input string req_dat);
        bit a;
        logic [7:0] v;
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b1), a);
        check_eq(req_hdr, int'(a), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            check_eq(req_dat, int'(v), int'(ref_mem[ref_ptr]));
            ref_ptr = (ref_ptr + 1) % MEMN;
        end
        bus_stop();
    endtask

    task automatic random_read(input int addr, input int n, input string req);
        write_frame(addr, 0, 1'b0, "R11", 8'h00, 1'b0);
        read_run(n, "R1", req);
    endtask

    task automatic poll(output bit acked);
        bus_start();
        send_byte(dev_byte(4'b1010, STRAP, 1'b0), acked);
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit a;
        int addr;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < MEMN; i++) ref_mem[i] = 8'hFF;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wq(4);

        // R12: released line and erased contents at counter 0.
        check_eq("R12", int'(sda_oe), 0);
        read_run(2, "R12", "R12");

        // R2: mismatched strap and wrong device type are not acknowledged.
        bus_start();
        send_byte(dev_byte(4'b1010, ~STRAP, 1'b0), a);
        check_eq("R2", int'(a), 0);
        send_byte(8'h00, a);
        check_eq("R2", int'(a), 0);
        bus_stop();
        bus_start();
        send_byte(dev_byte(4'b1011, STRAP, 1'b1), a);
        check_eq("R2", int'(a), 0);
        bus_stop();

        // R4: upper word-address bits ignored; R7: busy, then ready.
        write_frame(16'hF123, 1, 1'b1, "R3", 8'h5A, 1'b1);
        poll(a);
        check_eq("R7", int'(a), 0);
        wq(WC);
        poll(a);
        check_eq("R7", int'(a), 1);
        ref_ptr = 16'h124;
        read_run(1, "R9", "R9");
        random_read(16'h0123, 1, "R4");

        // R5: page overrun by two bytes wraps inside the page.
        write_frame(16'h02FE, 34, 1'b1, "R5", 8'h00, 1'b0);
        wq(WC + 20);
        random_read(16'h02E0, 32, "R5");

        // R6: pending bytes discarded by a repeated START before STOP.
        write_frame(16'h0400, 3, 1'b0, "R6", 8'h00, 1'b0);
        bus_start();
        bus_stop();
        poll(a);
        check_eq("R6", int'(a), 1);
        random_read(16'h0400, 3, "R6");

        // R8: write protect keeps storage and starts no write cycle.
        wp = 1'b1;
        write_frame(16'h0500, 4, 1'b1, "R8", 8'h00, 1'b0);
        wp = 1'b0;
        poll(a);
        check_eq("R8", int'(a), 1);
        random_read(16'h0500, 4, "R8");

        // R10: sequential read wraps from the last byte to address 0.
        write_frame(16'h0FFE, 2, 1'b1, "R3", 8'h00, 1'b0);
        wq(WC + 20);
        write_frame(16'h0000, 2, 1'b1, "R3", 8'h00, 1'b0);
        wq(WC + 20);
        random_read(16'h0FFE, 4, "R10");
        read_run(2, "R9", "R9");

        // Random rounds: page writes of random length, read back whole page.
        for (int it = 0; it < 6; it++) begin
            addr = int'($urandom % MEMN);
            n = 1 + int'($urandom % 36);
            write_frame(addr, n, 1'b1, "R3", 8'h00, 1'b0);
            wq(WC + 20);
            random_read(addr & ~31, 32, "R5");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule